// File: doc/BRIEF.md
# Reset-Strap Bus Agent Identity Assigner

This block gives one processor package its identity on a shared system bus. While reset is held, a set of active-low configuration straps is presented to it. At the first clock edge after reset is released it captures them once: two address straps give a cluster number, up to three request straps give a physical package number, and a topology select and a multi-threading enable decide how those are read. From the captured values it drives a bus agent ID for each logical processor in the package.

Each logical processor also owns an interrupt-controller ID register. At capture, the register is loaded with a packed word of cluster, package and logical index. Software can then overwrite it through a single write port and read it back through a registered read port. A request-strap pattern that names more than one package in quad mode is flagged as a strap error. The package number then falls back to zero.

Top module: `strap_id_assign`

## Requirements
- R1: Straps, topology select and threading enable are captured at the first rising clock edge on which `rst_n` is high. After that, changes on these inputs have no effect on any output until the next reset.
- R2: The cluster number is the bitwise inverse of the electrical address straps. Electrical 11 gives 0, 10 gives 1, 01 gives 2 and 00 gives 3.
- R3: With `topo_sel`=2 (quad), `req_strap_n` bit 0 is request strap 1, bit 1 is strap 2 and bit 2 is strap 3. All high gives package 0. Only bit 2 low gives 1. Only bit 1 low gives 2. Only bit 0 low gives 3.
- R4: In quad mode, a pattern with two or more request straps low sets `strap_err_o` and forces package 0. The flag holds until the next reset. It stays 0 in every other case.
- R5: With `topo_sel`=1 (dual), only `req_strap_n[0]` is read. High gives package 0 and low gives package 1. Bits 2:1 are ignored.
- R6: With `topo_sel`=0 (single) or 3 (treated as single), no request strap is read and the package is 0.
- R7: With threading disabled, `lp_en_o`=01. Logical processor 0 gets agent ID P, where P is the package number, and logical processor 1 gets agent ID 0.
- R8: With threading enabled, `lp_en_o`=11 and logical processor i gets agent ID 2·P+i. Agent ID i occupies `agent_id_o[3i+2:3i]`.
- R9: At capture, the ID register of each present logical processor i is loaded with {cluster[4:3], package[2:1], i[0]}. The register of an absent processor is loaded with 0.
- R10: A write (`wr_en`, `wr_sel`, `wr_data`) to a present processor's register takes effect at the next clock edge. Writes to an absent processor, writes during reset and writes in the capture cycle are ignored. `rd_data` shows the register chosen by `rd_sel` one clock later.
- R11: While `rst_n` is low, every output reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; its release starts capture |
| addr_strap_n | input | 2 | Active-low cluster straps |
| req_strap_n | input | 3 | Active-low request straps, bit 0 = strap 1 |
| topo_sel | input | 2 | 0 single, 1 dual, 2 quad, 3 single |
| mt_en | input | 1 | Multi-threading enable |
| wr_en | input | 1 | ID register write strobe |
| wr_sel | input | 1 | Logical processor being written |
| wr_data | input | 5 | New ID register value |
| rd_sel | input | 1 | Logical processor being read |
| rd_data | output | 5 | Registered ID register read data |
| cluster_o | output | 2 | Captured cluster number |
| pkg_o | output | 2 | Captured physical package number |
| agent_id_o | output | 6 | Agent IDs of both logical processors, packed |
| lp_en_o | output | 2 | Present logical processors |
| strap_err_o | output | 1 | Sticky invalid-strap flag |

## Verification
A wrong capture register shows up at the first sampling point after release. It appears as a wrong cluster, package or agent ID, or as outputs that move when the straps are scrambled after capture. A bad load or write path in the ID register file appears on `rd_data` one clock after the register is selected. Every present and absent processor is read back after capture and after each write. Random strap patterns across all four topology codes and both threading modes are mixed with every quad request pattern. This exposes decode errors at the next capture.

// File: rtl/strap_id_pkg.sv
package strap_id_pkg;
   typedef enum logic [1:0] {
      TOPO_SINGLE = 2'd0,
      TOPO_DUAL   = 2'd1,
      TOPO_QUAD   = 2'd2,
      TOPO_RSVD   = 2'd3
   } topo_e;
endpackage

// File: rtl/strap_decode.sv
module strap_decode
   import strap_id_pkg::*;
#(
   parameter int CLUSTER_W = 2,
   parameter int PKG_W     = 2,
   parameter int REQ_W     = 3
) (
   input  logic [CLUSTER_W-1:0] addr_strap_n_i,
   input  logic [REQ_W-1:0]     req_strap_n_i,
   input  topo_e                topo_i,
   output logic [CLUSTER_W-1:0] cluster_o,
   output logic [PKG_W-1:0]     pkg_o,
   output logic                 err_o
);
   generate
      if (REQ_W >= (1 << PKG_W)) begin : g_bad_req
         $error("strap_decode: REQ_W too large for PKG_W");
      end
   endgenerate

   logic [REQ_W-1:0] req_low;
   assign req_low   = ~req_strap_n_i;
   // cluster code is the inverted electrical value
   assign cluster_o = ~addr_strap_n_i;

   always_comb begin
      pkg_o = '0;
      err_o = 1'b0;
      unique case (topo_i)
         TOPO_DUAL: pkg_o = PKG_W'(req_low[0]);
         TOPO_QUAD: begin
            if ($countones(req_low) > 1) begin
               err_o = 1'b1;
            end else begin
               for (int k = 0; k < REQ_W; k++) begin
                  if (req_low[k]) pkg_o = PKG_W'(REQ_W - k);
               end
            end
         end
         default: pkg_o = '0;
      endcase
   end
endmodule

// File: rtl/id_regfile.sv
module id_regfile #(
   parameter int NUM_LP = 2,
   parameter int ID_W   = 5,
   parameter int SEL_W  = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load_i,
   input  logic [NUM_LP*ID_W-1:0] init_i,
   input  logic [NUM_LP-1:0]      lp_en_i,
   input  logic                   wr_en_i,
   input  logic [SEL_W-1:0]       wr_sel_i,
   input  logic [ID_W-1:0]        wr_data_i,
   input  logic [SEL_W-1:0]       rd_sel_i,
   output logic [ID_W-1:0]        rd_data_o
);
   generate
      if (NUM_LP != (1 << SEL_W)) begin : g_bad_sel
         $error("id_regfile: NUM_LP must equal 2**SEL_W");
      end
   endgenerate

   logic [ID_W-1:0] id_q [NUM_LP];

   generate
      for (genvar g = 0; g < NUM_LP; g++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               id_q[g] <= '0;
            end else if (load_i) begin
               id_q[g] <= init_i[g*ID_W +: ID_W];
            end else if (wr_en_i && (wr_sel_i == SEL_W'(g)) && lp_en_i[g]) begin
               id_q[g] <= wr_data_i;
            end
         end

         // R9
         absent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!lp_en_i[g] && !load_i) |-> (id_q[g] == '0));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_data_o <= '0;
      else        rd_data_o <= id_q[rd_sel_i];
   end

   // R10
   wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !load_i && lp_en_i[wr_sel_i]) |=> (id_q[$past(wr_sel_i)] == $past(wr_data_i)));
endmodule

// File: rtl/strap_id_assign.sv
module strap_id_assign
   import strap_id_pkg::*;
#(
   parameter int CLUSTER_W = 2,
   parameter int PKG_W     = 2,
   parameter int LP_W      = 1,
   parameter int REQ_W     = 3,
   localparam int NUM_LP   = 1 << LP_W,
   localparam int AGENT_W  = PKG_W + LP_W,
   localparam int ID_W     = CLUSTER_W + PKG_W + LP_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [CLUSTER_W-1:0]      addr_strap_n,
   input  logic [REQ_W-1:0]          req_strap_n,
   input  logic [1:0]                topo_sel,
   input  logic                      mt_en,
   input  logic                      wr_en,
   input  logic [LP_W-1:0]           wr_sel,
   input  logic [ID_W-1:0]           wr_data,
   input  logic [LP_W-1:0]           rd_sel,
   output logic [ID_W-1:0]           rd_data,
   output logic [CLUSTER_W-1:0]      cluster_o,
   output logic [PKG_W-1:0]          pkg_o,
   output logic [NUM_LP*AGENT_W-1:0] agent_id_o,
   output logic [NUM_LP-1:0]         lp_en_o,
   output logic                      strap_err_o
);
   generate
      if (CLUSTER_W < 1 || PKG_W < 1 || LP_W < 1) begin : g_bad_w
         $error("strap_id_assign: field widths must be at least 1");
      end
   endgenerate

   logic [CLUSTER_W-1:0] cluster_d, cluster_q;
   logic [PKG_W-1:0]     pkg_d, pkg_q;
   logic                 err_d, err_q, mt_q, armed_q;
   topo_e                topo_q;
   logic [NUM_LP*ID_W-1:0] init_w;

   strap_decode #(.CLUSTER_W(CLUSTER_W), .PKG_W(PKG_W), .REQ_W(REQ_W)) u_dec (
      .addr_strap_n_i (addr_strap_n),
      .req_strap_n_i  (req_strap_n),
      .topo_i         (topo_e'(topo_sel)),
      .cluster_o      (cluster_d),
      .pkg_o          (pkg_d),
      .err_o          (err_d)
   );

   // one-shot capture on the first edge after reset release
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q   <= 1'b1;
         cluster_q <= '0;
         pkg_q     <= '0;
         err_q     <= 1'b0;
         mt_q      <= 1'b0;
         topo_q    <= TOPO_SINGLE;
      end else if (armed_q) begin
         armed_q   <= 1'b0;
         cluster_q <= cluster_d;
         pkg_q     <= pkg_d;
         err_q     <= err_d;
         mt_q      <= mt_en;
         topo_q    <= topo_e'(topo_sel);
      end
   end

   generate
      for (genvar i = 0; i < NUM_LP; i++) begin : g_lp
         assign init_w[i*ID_W +: ID_W] = (mt_en || i == 0) ?
            {cluster_d, pkg_d, LP_W'(i)} : '0;
         if (i == 0) begin : g_lp0
            assign agent_id_o[0 +: AGENT_W] = mt_q ? {pkg_q, LP_W'(0)} : AGENT_W'(pkg_q);
            assign lp_en_o[0] = !armed_q;
         end else begin : g_lpn
            assign agent_id_o[i*AGENT_W +: AGENT_W] = mt_q ? {pkg_q, LP_W'(i)} : '0;
            assign lp_en_o[i] = !armed_q && mt_q;
         end
      end
   endgenerate

   assign cluster_o   = cluster_q;
   assign pkg_o       = pkg_q;
   assign strap_err_o = err_q;

   id_regfile #(.NUM_LP(NUM_LP), .ID_W(ID_W), .SEL_W(LP_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (armed_q),
      .init_i    (init_w),
      .lp_en_i   (lp_en_o),
      .wr_en_i   (wr_en),
      .wr_sel_i  (wr_sel),
      .wr_data_i (wr_data),
      .rd_sel_i  (rd_sel),
      .rd_data_o (rd_data)
   );

   // R1
   capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q |=> ($stable(cluster_q) && $stable(pkg_q) && $stable(err_q) && $stable(mt_q)));
   // R4
   err_pkg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> (pkg_q == '0 && topo_q == TOPO_QUAD));
   // R6
   single_pkg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && (topo_q == TOPO_SINGLE || topo_q == TOPO_RSVD)) |-> (pkg_q == '0));
   // R5
   dual_pkg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && topo_q == TOPO_DUAL) |-> (pkg_q <= PKG_W'(1)));
endmodule

// File: tb/strap_id_assign_bench.sv
module strap_id_assign_bench;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] addr_strap_n;
   logic [2:0] req_strap_n;
   logic [1:0] topo_sel;
   logic       mt_en, wr_en, wr_sel, rd_sel;
   logic [4:0] wr_data, rd_data;
   logic [1:0] cluster_o, pkg_o, lp_en_o;
   logic [5:0] agent_id_o;
   logic       strap_err_o;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   strap_id_assign u_strap_id_assign (
      .clk(clk), .rst_n(rst_n), .addr_strap_n(addr_strap_n), .req_strap_n(req_strap_n),
      .topo_sel(topo_sel), .mt_en(mt_en), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .cluster_o(cluster_o),
      .pkg_o(pkg_o), .agent_id_o(agent_id_o), .lp_en_o(lp_en_o), .strap_err_o(strap_err_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_pkg(input logic [1:0] topo, input logic [2:0] rn);
      logic [2:0] low = ~rn;
      if (topo == 2'd1) return {1'b0, low[0]};
      if (topo == 2'd2) begin
         case (low)
            3'b000: return 2'd0;
            3'b100: return 2'd1;
            3'b010: return 2'd2;
            3'b001: return 2'd3;
            default: return 2'd0;
         endcase
      end
      return 2'd0;
   endfunction

   function automatic logic exp_err(input logic [1:0] topo, input logic [2:0] rn);
      logic [2:0] low = ~rn;
      return (topo == 2'd2) && ($countones(low) > 1);
   endfunction

   task automatic read_lp(input logic sel, input logic [4:0] exp, input string tag);
      rd_sel = sel;
      @(negedge clk);
      chk(tag, rd_data, exp);
   endtask

   task automatic run_case(input logic [1:0] topo, input logic mt,
                           input logic [1:0] an, input logic [2:0] rn);
      logic [1:0] cl, p;
      logic       e;
      logic [4:0] idv [2];
      logic [4:0] d;
      rst_n = 1'b0;
      addr_strap_n = an; req_strap_n = rn; topo_sel = topo; mt_en = mt;
      wr_en = 1'b1; wr_sel = 1'b0; wr_data = 5'h1f; rd_sel = 1'b0;
      @(negedge clk);
      @(negedge clk);
      // R11 outputs zero during reset
      chk("R11 reset outputs", {rd_data, cluster_o, pkg_o, agent_id_o, lp_en_o, strap_err_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      cl = ~an; p = exp_pkg(topo, rn); e = exp_err(topo, rn);
      chk("R2 cluster", cluster_o, cl);
      chk(topo == 2'd2 ? "R3 quad pkg" : (topo == 2'd1 ? "R5 dual pkg" : "R6 single pkg"), pkg_o, p);
      chk("R4 strap error", strap_err_o, e);
      if (mt) begin
         chk("R8 lp enable", lp_en_o, 2'b11);
         chk("R8 agent ids", agent_id_o, {p, 1'b1, p, 1'b0});
      end else begin
         chk("R7 lp enable", lp_en_o, 2'b01);
         chk("R7 agent ids", agent_id_o, {3'b000, 1'b0, p});
      end
      // R1 scramble inputs after capture
      addr_strap_n = 2'($urandom); req_strap_n = 3'($urandom);
      topo_sel = 2'($urandom); mt_en = 1'($urandom);
      @(negedge clk);
      chk("R1 hold after capture", {cluster_o, pkg_o, strap_err_o, agent_id_o, lp_en_o},
          {cl, p, e, mt ? {p, 1'b1, p, 1'b0} : {4'b0000, p}, mt ? 2'b11 : 2'b01});
      idv[0] = {cl, p, 1'b0};
      idv[1] = mt ? {cl, p, 1'b1} : 5'd0;
      // R9 / R10 capture-cycle write ignored
      read_lp(1'b0, idv[0], "R9 R10 load lp0");
      read_lp(1'b1, idv[1], "R9 load lp1");
      for (int i = 0; i < 2; i++) begin
         d = 5'($urandom);
         wr_en = 1'b1; wr_sel = 1'(i); wr_data = d;
         @(negedge clk);
         wr_en = 1'b0;
         if (i == 0 || mt) idv[i] = d;
         read_lp(1'(i), idv[i], "R10 write readback");
      end
      read_lp(1'b0, idv[0], "R10 lp0 kept");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      rst_n = 1'b0;
      // directed: every quad pattern, both threading modes
      for (int r = 0; r < 8; r++) begin
         run_case(2'd2, 1'b1, 2'(r), 3'(r));
         run_case(2'd2, 1'b0, 2'(r + 1), 3'(r));
      end
      run_case(2'd1, 1'b1, 2'b11, 3'b110);   // dual, strap 1 low
      run_case(2'd1, 1'b0, 2'b00, 3'b001);   // dual, others low ignored
      run_case(2'd0, 1'b1, 2'b10, 3'b000);   // single ignores straps
      run_case(2'd3, 1'b1, 2'b01, 3'b011);   // reserved code as single
      for (int n = 0; n < 60; n++) begin
         run_case(2'($urandom), 1'($urandom), 2'($urandom), 3'($urandom));
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule